// File: doc/BRIEF.md
# Interrupt Acknowledge Nesting Stack

This block keeps the service history of nested interrupts for a two-channel serial controller. There are three interrupt classes: modem, transmit and receive. The host programs one 8-bit match code for each class. During an acknowledge cycle, the block compares the low 7 address bits with those codes. The matching class that also has a pending request is the one acknowledged.

The level of that class is pushed onto a three-entry nesting stack. A later end-of-interrupt write takes it off again. The stack is read as one byte whose entries are mirrored: the high bit of each entry sits at the top of the byte and the low bit at the bottom, and the entries fill in from both edges toward the centre.

Two further outputs serve the rest of the controller. One flag says whether any service is in progress. A one-cycle pulse, with its class code, marks each accepted acknowledge.

Top module: `irq_nest_stack`

## Requirements
- R1: After a synchronous active-low reset, the stack byte reads 0x00, all three match codes read 0x00, `in_service` is 0 and `ack_pulse` is 0.
- R2: Levels are 2-bit codes: 00 means idle, 01 means modem, 10 means transmit and 11 means receive. The same code appears on `ack_class` and in every stack entry.
- R3: In `stack_byte`, the current entry sits on bits 7 (high) and 0 (low), the previous entry on bits 6 and 1, and the oldest entry on bits 5 and 2. Bits 4 and 3 always read 0.
- R4: The host selects a match code with `cfg_sel` (0 = modem, 1 = transmit, 2 = receive) and writes it with `cfg_wr`. `cfg_rdata` returns all 8 stored bits. Selecting 3 reads 0x00, and a write with select 3 is ignored. Only bits 6:0 of a code are compared with `ack_addr[6:0]`; bit 7 has no effect on matching.
- R5: An acknowledge is accepted only when `ack_req` is 1, a class code matches the address, and that class's bit in `pend` is 1. The `pend` bits are: bit 0 modem, bit 1 transmit, bit 2 receive.
- R6: When several classes both match and are pending, receive wins over transmit, and transmit wins over modem.
- R7: On the clock edge that ends an accepted acknowledge, the new level becomes the current entry. The old current entry moves to previous, and the old previous entry moves to oldest.
- R8: An accepted acknowledge while three entries are already stacked discards the oldest entry.
- R9: An `eoi_wr` without an accepted acknowledge pops the stack. Each entry moves one place outward and the oldest becomes 00. A pop on an empty stack changes nothing.
- R10: When an accepted acknowledge and `eoi_wr` occur in the same cycle and the stack is not empty, the current entry is replaced by the new level and the deeper entries keep their values.
- R11: `in_service` is 1 exactly when the current entry is non-zero.
- R12: `ack_pulse` is high for exactly one cycle after each accepted acknowledge, with `ack_class` carrying the accepted level. `ack_class` is 00 when no pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the selected match code |
| cfg_sel | input | 2 | Match code select: 0 modem, 1 transmit, 2 receive |
| cfg_wdata | input | 8 | Match code write data |
| cfg_rdata | output | 8 | Selected match code readback |
| ack_req | input | 1 | Host acknowledge cycle in progress |
| ack_addr | input | 7 | Host address bits compared with the match codes |
| pend | input | 3 | Pending requests: bit 0 modem, bit 1 transmit, bit 2 receive |
| eoi_wr | input | 1 | End-of-interrupt write, pops the stack |
| stack_byte | output | 8 | Mirrored nesting history |
| in_service | output | 1 | Current level is non-zero |
| ack_pulse | output | 1 | One-cycle pulse per accepted acknowledge |
| ack_class | output | 2 | Level accepted with the pulse |

## Verification
Some properties can be checked on every cycle, so the assertions cover them:
- bits 4 and 3 of the stack byte stay zero;
- each pulse carries a non-zero class that equals the new current entry;
- a push shifts the old entries inward, and a pop shifts them outward and clears the oldest;
- a simultaneous push and pop keeps the deeper entries;
- `in_service` follows the current entry;
- no pulse appears without a request.

Other behaviours depend on programmed codes and on a particular history, so only the bench scenarios can show them:
- bit 7 of a match code being ignored;
- the receive-over-transmit-over-modem choice;
- matches rejected because the class is not pending;
- the oldest entry being lost on the fourth push;
- an empty pop doing nothing.

// File: rtl/irq_nest_pkg.sv
// Shared types for the interrupt acknowledge nesting stack.
// Assumes three interrupt classes whose level code is the class index plus one.
package irq_nest_pkg;
    typedef enum logic [1:0] {
        LVL_NONE  = 2'b00,
        LVL_MODEM = 2'b01,
        LVL_TX    = 2'b10,
        LVL_RX    = 2'b11
    } lvl_t;

    localparam int NUM_CLASSES = 3;
endpackage

// File: rtl/match_bank.sv
// Holds one host-programmable match code for each interrupt class and compares
// the low ADDR_W bits of every code with the acknowledge address.
// Assumes SEL_W is wide enough to select all classes; select values beyond the
// last class read zero and ignore writes.
module match_bank #(
    parameter int REG_W  = 8,
    parameter int ADDR_W = 7,
    parameter int NCLS   = 3,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [REG_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] addr,
    output logic [REG_W-1:0]  rdata,
    output logic [NCLS-1:0]   hit
);
    logic [REG_W-1:0] code_q [NCLS];

    for (genvar g = 0; g < NCLS; g++) begin : g_code
        // Store the code when the host writes this class's slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[g] <= '0;
            end else if (wr_en && (sel == SEL_W'(g))) begin
                code_q[g] <= wdata;
            end
        end

        // Compare only the address-width part of the code.
        assign hit[g] = (code_q[g][ADDR_W-1:0] == addr);
    end

    // Return the selected code, or zero for an unused select value.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCLS; i++) begin
            if (sel == SEL_W'(i)) begin
                rdata = code_q[i];
            end
        end
    end
endmodule

// File: rtl/class_select.sv
// Chooses the acknowledged class from the classes that both match and are
// pending. A higher class index wins. Assumes a class's level code is its
// index plus one.
module class_select
    import irq_nest_pkg::*;
#(
    parameter int NCLS = 3
) (
    input  logic            ack,
    input  logic [NCLS-1:0] hit,
    input  logic [NCLS-1:0] pend,
    output logic            accept,
    output lvl_t            cls
);
    logic [NCLS-1:0] cand;

    assign cand = hit & pend;

    // Scan upward so the highest candidate index is the one that remains.
    always_comb begin
        cls = LVL_NONE;
        for (int i = 0; i < NCLS; i++) begin
            if (cand[i]) begin
                cls = lvl_t'(2'(i + 1));
            end
        end
    end

    assign accept = ack && (cls != LVL_NONE);
endmodule

// File: rtl/nest_stack.sv
// A DEPTH-entry stack of interrupt levels, presented as a mirrored byte.
// Entry k puts its high bit on bit REG_W-1-k and its low bit on bit k, and
// the centre bits read zero. A push drops the oldest entry when the stack is
// full. A pop on an empty stack does nothing. A push and a pop in the same
// cycle replace the current entry. Assumes 2*DEPTH <= REG_W.
module nest_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  lvl_t             push_lvl,
    input  logic             pop,
    output logic [REG_W-1:0] stk_byte,
    output lvl_t             cur_lvl
);
    lvl_t lvl_q [DEPTH];
    logic busy;

    assign busy = (lvl_q[0] != LVL_NONE);

    // Update the entries on a push, a pop, or a push and pop together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                lvl_q[k] <= LVL_NONE;
            end
        end else if (push && pop && busy) begin
            lvl_q[0] <= push_lvl;
        end else if (push) begin
            lvl_q[0] <= push_lvl;
            for (int k = 1; k < DEPTH; k++) begin
                lvl_q[k] <= lvl_q[k-1];
            end
        end else if (pop && busy) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                lvl_q[k] <= lvl_q[k+1];
            end
            lvl_q[DEPTH-1] <= LVL_NONE;
        end
    end

    // Map the entries onto the mirrored byte; the centre bits stay zero.
    always_comb begin
        stk_byte = '0;
        for (int k = 0; k < DEPTH; k++) begin
            stk_byte[REG_W-1-k] = lvl_q[k][1];
            stk_byte[k]         = lvl_q[k][0];
        end
    end

    assign cur_lvl = lvl_q[0];
endmodule

// File: rtl/irq_nest_stack.sv
// Top level of the interrupt acknowledge nesting stack. It decodes which class
// is acknowledged from the programmed match codes, pushes that level onto the
// nesting stack, pops the stack on end-of-interrupt writes, and registers a
// one-cycle pulse for each accepted acknowledge.
// Assumes the acknowledge and EOI inputs are already synchronous to clk.
module irq_nest_stack
    import irq_nest_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [1:0]             cfg_sel,
    input  logic [REG_W-1:0]       cfg_wdata,
    output logic [REG_W-1:0]       cfg_rdata,
    input  logic                   ack_req,
    input  logic [ADDR_W-1:0]      ack_addr,
    input  logic [NUM_CLASSES-1:0] pend,
    input  logic                   eoi_wr,
    output logic [REG_W-1:0]       stack_byte,
    output logic                   in_service,
    output logic                   ack_pulse,
    output logic [1:0]             ack_class
);
    localparam int SEL_W = $clog2(NUM_CLASSES + 1);

    logic [NUM_CLASSES-1:0] hit;
    logic                   accept;
    lvl_t                   sel_lvl;
    lvl_t                   cur_lvl;

    match_bank #(
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W),
        .NCLS   (NUM_CLASSES),
        .SEL_W  (SEL_W)
    ) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .addr  (ack_addr),
        .rdata (cfg_rdata),
        .hit   (hit)
    );

    class_select #(
        .NCLS (NUM_CLASSES)
    ) u_sel (
        .ack    (ack_req),
        .hit    (hit),
        .pend   (pend),
        .accept (accept),
        .cls    (sel_lvl)
    );

    nest_stack #(
        .DEPTH (DEPTH),
        .REG_W (REG_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_lvl (sel_lvl),
        .pop      (eoi_wr),
        .stk_byte (stack_byte),
        .cur_lvl  (cur_lvl)
    );

    // Register the acknowledge pulse and its class so they line up with the stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_pulse <= 1'b0;
            ack_class <= 2'b00;
        end else begin
            ack_pulse <= accept;
            ack_class <= accept ? sel_lvl : LVL_NONE;
        end
    end

    assign in_service = (cur_lvl != LVL_NONE);
endmodule

// File: rtl/irq_nest_stack_chk.sv
// Checker for irq_nest_stack. It watches only the ports and relates the
// stack byte to the acknowledge and EOI history.
module irq_nest_stack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_req,
    input logic       eoi_wr,
    input logic [7:0] stack_byte,
    input logic       in_service,
    input logic       ack_pulse,
    input logic [1:0] ack_class
);
    logic [1:0] cur, mid, old;

    assign cur = {stack_byte[7], stack_byte[0]};
    assign mid = {stack_byte[6], stack_byte[1]};
    assign old = {stack_byte[5], stack_byte[2]};

    AST_CENTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stack_byte[4:3] == 2'b00); // R3

    AST_PULSE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> (ack_class != 2'b00) && (cur == ack_class)); // R12

    AST_NO_REQ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_req) |-> !ack_pulse); // R5

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse && !$past(eoi_wr)) |-> (mid == $past(cur)) && (old == $past(mid))); // R7

    AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eoi_wr) && !ack_pulse && ($past(cur) != 2'b00))
            |-> (cur == $past(mid)) && (mid == $past(old)) && (old == 2'b00)); // R9

    AST_REPLACE_KEEPS_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse && $past(eoi_wr) && ($past(cur) != 2'b00))
            |-> (mid == $past(mid)) && (old == $past(old))); // R10

    AST_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        in_service == (cur != 2'b00)); // R11
endmodule

bind irq_nest_stack irq_nest_stack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_req    (ack_req),
    .eoi_wr     (eoi_wr),
    .stack_byte (stack_byte),
    .in_service (in_service),
    .ack_pulse  (ack_pulse),
    .ack_class  (ack_class)
);

// File: tb/sim_irq_nest_stack.sv
// Scoreboard bench. Driver tasks apply one cycle of stimulus, update a
// reference model and queue the expected outputs. A monitor pops each item
// shortly after the clock edge and compares it with the design's outputs.
module sim_irq_nest_stack;
    typedef struct {
        logic [7:0] byte_v;
        logic       insv;
        logic       pulse;
        logic [1:0] cls;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       ack_req = 1'b0;
    logic [6:0] ack_addr = 7'h00;
    logic [2:0] pend = 3'b000;
    logic       eoi_wr = 1'b0;
    logic [7:0] stack_byte;
    logic       in_service;
    logic       ack_pulse;
    logic [1:0] ack_class;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t q[$];
    logic [7:0] ref_code [3];
    logic [1:0] ref_s [3];

    always #5 clk = ~clk;

    irq_nest_stack u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .ack_req    (ack_req),
        .ack_addr   (ack_addr),
        .pend       (pend),
        .eoi_wr     (eoi_wr),
        .stack_byte (stack_byte),
        .in_service (in_service),
        .ack_pulse  (ack_pulse),
        .ack_class  (ack_class)
    );

    function automatic logic [7:0] ref_byte();
        return {ref_s[0][1], ref_s[1][1], ref_s[2][1], 2'b00,
                ref_s[2][0], ref_s[1][0], ref_s[0][0]};
    endfunction

    task automatic push_exp(input logic p, input logic [1:0] c, input string tag);
        exp_t e;
        e.byte_v = ref_byte();
        e.insv   = (ref_s[0] != 2'b00);
        e.pulse  = p;
        e.cls    = c;
        e.tag    = tag;
        q.push_back(e);
    endtask

    // One cycle of acknowledge and EOI stimulus, applied to the model as well.
    task automatic step(input logic a, input logic [6:0] ad, input logic [2:0] pd,
                        input logic e, input string tag);
        logic [1:0] c;
        logic acc;
        @(negedge clk);
        ack_req = a; ack_addr = ad; pend = pd; eoi_wr = e; cfg_wr = 1'b0;
        c = 2'b00;
        for (int i = 0; i < 3; i++) begin
            if (ref_code[i][6:0] == ad && pd[i]) c = 2'(i + 1);
        end
        acc = a && (c != 2'b00);
        if (acc && e && ref_s[0] != 2'b00) begin
            ref_s[0] = c;
        end else if (acc) begin
            ref_s[2] = ref_s[1]; ref_s[1] = ref_s[0]; ref_s[0] = c;
        end else if (e && ref_s[0] != 2'b00) begin
            ref_s[0] = ref_s[1]; ref_s[1] = ref_s[2]; ref_s[2] = 2'b00;
        end
        push_exp(acc, acc ? c : 2'b00, tag);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        ack_req = 1'b0; eoi_wr = 1'b0;
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        if (s != 2'd3) ref_code[s] = d;
        push_exp(1'b0, 2'b00, "R4");
    endtask

    task automatic cfg_check(input logic [1:0] s, input string tag);
        logic [7:0] want;
        @(negedge clk);
        cfg_wr = 1'b0; ack_req = 1'b0; eoi_wr = 1'b0; cfg_sel = s;
        #1;
        want = (s == 2'd3) ? 8'h00 : ref_code[s];
        n_checks++;
        if (cfg_rdata !== want) begin
            n_fail++;
            $display("FAIL %s: cfg_rdata sel=%0d actual=%h expected=%h", tag, s, cfg_rdata, want);
        end
    endtask

    // Monitor: compare each queued expectation just after the clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (stack_byte !== e.byte_v || in_service !== e.insv ||
                    ack_pulse !== e.pulse || ack_class !== e.cls) begin
                    n_fail++;
                    $display("FAIL %s: actual byte=%h insv=%b pulse=%b cls=%b expected byte=%h insv=%b pulse=%b cls=%b",
                             e.tag, stack_byte, in_service, ack_pulse, ack_class,
                             e.byte_v, e.insv, e.pulse, e.cls);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            ref_code[i] = 8'h00;
            ref_s[i] = 2'b00;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of the stack, flags and match codes.
        #1;
        n_checks++;
        if (stack_byte !== 8'h00 || in_service !== 1'b0 || ack_pulse !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual byte=%h insv=%b pulse=%b expected byte=00 insv=0 pulse=0",
                     stack_byte, in_service, ack_pulse);
        end
        for (int s = 0; s < 3; s++) cfg_check(2'(s), "R1");

        // R4: program the codes, with bit 7 set on the receive code; select 3 is ignored.
        cfg_write(2'd0, 8'h12);
        cfg_write(2'd1, 8'h25);
        cfg_write(2'd2, 8'h93);
        cfg_write(2'd3, 8'h7F);
        for (int s = 0; s < 4; s++) cfg_check(2'(s), "R4");

        // R7 and R2: a modem acknowledge pushes level 01.
        step(1'b1, 7'h12, 3'b001, 1'b0, "R7");
        // R4: the receive code matches on bits 6:0 only.
        step(1'b1, 7'h13, 3'b100, 1'b0, "R4");
        // R5: a match without a pending request is rejected.
        step(1'b1, 7'h25, 3'b001, 1'b0, "R5");
        // R5: no acknowledge request means no acceptance.
        step(1'b0, 7'h25, 3'b010, 1'b0, "R5");
        // R12: the pulse lasts one cycle; an idle cycle follows.
        step(1'b0, 7'h00, 3'b000, 1'b0, "R12");
        // R3: a transmit push fills all three entries.
        step(1'b1, 7'h25, 3'b010, 1'b0, "R3");
        // R8: a fourth push discards the oldest entry.
        step(1'b1, 7'h12, 3'b001, 1'b0, "R8");
        // R9: pop until empty, then pop once more.
        step(1'b0, 7'h00, 3'b000, 1'b1, "R9");
        step(1'b0, 7'h00, 3'b000, 1'b1, "R9");
        step(1'b0, 7'h00, 3'b000, 1'b1, "R11");
        step(1'b0, 7'h00, 3'b000, 1'b1, "R9");

        // R6: all three codes equal, so priority decides.
        cfg_write(2'd0, 8'h40);
        cfg_write(2'd1, 8'h40);
        cfg_write(2'd2, 8'hC0);
        step(1'b1, 7'h40, 3'b111, 1'b0, "R6");
        step(1'b1, 7'h40, 3'b011, 1'b0, "R6");
        step(1'b1, 7'h40, 3'b001, 1'b0, "R6");
        // R10: a push and a pop together replace the current entry.
        step(1'b1, 7'h40, 3'b100, 1'b1, "R10");
        // R10: a push and a pop together on an empty stack is a plain push.
        step(1'b0, 7'h00, 3'b000, 1'b1, "R9");
        step(1'b0, 7'h00, 3'b000, 1'b1, "R9");
        step(1'b0, 7'h00, 3'b000, 1'b1, "R9");
        step(1'b1, 7'h40, 3'b010, 1'b1, "R10");
        step(1'b0, 7'h00, 3'b000, 1'b0, "R2");
        step(1'b0, 7'h00, 3'b000, 1'b0, "R11");

        repeat (3) @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule